// File: doc/BRIEF.md
# Two-Requester Parking Grant Arbiter

This block decides, each clock cycle, which of two requesters owns a shared resource. The primary requester has priority. One cycle in which its request is sampled high earns it a grant for the next `HOLD_CYCLES` cycles (two by default), even if the request was only a single-cycle pulse. If the request is seen again while that window is open, the window restarts from the new sample.

In every cycle where the primary requester holds no grant, the grant goes to the secondary requester. The resource therefore never sits idle with no owner: with no requests pending, the grant rests on the secondary side. The secondary request input does not change who gets the grant. The grant on that side is implied whenever the primary side is not being served.

Both grants come straight from flip-flop state through a single OR reduction, so they are stable for the whole cycle. Reset is synchronous and active high.

Top module: `park_arbiter`

## Requirements
- R1: `gnt_pri` and `gnt_sec` are never high in the same cycle.
- R2: When `req_pri` is sampled high at a rising edge, `gnt_pri` is high in each of the `HOLD_CYCLES` cycles that follow that edge (2 cycles with the default), even if `req_pri` was high for one cycle only.
- R3: When `req_sec` is the only request sampled high and no primary hold window extends past that edge, `gnt_sec` is high in the next cycle.
- R4: When neither request is active and no hold window is open, the grant parks on `gnt_sec` (`gnt_sec` = 1, `gnt_pri` = 0) instead of leaving both grants low.
- R5: Exactly one of the two grants is high in every cycle, including the first cycle after reset.
- R6: If `req_pri` was low at each of the last `HOLD_CYCLES` rising edges, `gnt_pri` is low.
- R7: While `rst` is high and in the first cycle after it is released, the outputs are `gnt_pri` = 0 and `gnt_sec` = 1.
- R8: `req_sec` has no effect on `gnt_pri`. When both requests are sampled high together, the primary requester wins the following cycles.
- R9: Back-to-back or overlapping `req_pri` samples keep `gnt_pri` high without a gap, until `HOLD_CYCLES` cycles after the last edge at which `req_pri` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_pri | input | 1 | Request from the priority requester |
| req_sec | input | 1 | Request from the secondary requester |
| gnt_pri | output | 1 | Grant to the priority requester |
| gnt_sec | output | 1 | Grant to the secondary requester, also the parked state |

## Verification
A fresh secondary-only request can arrive in the same cycle as the tail of a primary hold window. Two functions then meet in one cycle: the hold rule (R2) and the fast response for a lone secondary request (R3). The bench provokes this by raising `req_sec` in the cycle right after a one-cycle primary pulse, and again by raising both requests in the same cycle. It judges the outcome against a reference history of sampled primary requests. The hold must win in the overlap, and the secondary grant must appear exactly in the first cycle the window has closed.

// File: rtl/park_arbiter_pkg.sv
package park_arbiter_pkg;

  // Grant vector encoding: bit 1 = primary, bit 0 = secondary.
  typedef enum logic [1:0] {
    OWNER_SEC = 2'b01,
    OWNER_PRI = 2'b10
  } owner_e;

  function automatic owner_e pick_owner(input logic pri_busy);
    return pri_busy ? OWNER_PRI : OWNER_SEC;
  endfunction

endpackage

// File: rtl/req_history.sv
// Shift register holding the last DEPTH samples of the primary request.
module req_history #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_in,
  output logic [DEPTH-1:0] taps
);

  logic [DEPTH-1:0] stage_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= req_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= {stage_q[DEPTH-2:0], req_in};
      end
    end
  endgenerate

  assign taps = stage_q;

endmodule

// File: rtl/hold_window.sv
// Open while any of the recorded samples was a primary request.
module hold_window #(
  parameter int DEPTH = 2
) (
  input  logic [DEPTH-1:0] taps,
  output logic             busy
);

  always_comb begin
    busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      busy = busy | taps[i];
    end
  end

endmodule

// File: rtl/grant_park.sv
// Maps the window state to one-hot grants; idle parks on the secondary side.
module grant_park
  import park_arbiter_pkg::*;
(
  input  logic busy,
  output logic gnt_pri,
  output logic gnt_sec
);

  owner_e owner;

  always_comb begin
    owner = pick_owner(busy);
  end

  assign gnt_pri = owner[1];
  assign gnt_sec = owner[0];

endmodule

// File: rtl/park_arbiter.sv
module park_arbiter #(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_pri,
  input  logic req_sec,
  output logic gnt_pri,
  output logic gnt_sec
);

  localparam int TapW = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;

  logic [TapW-1:0] pri_taps;
  logic            pri_busy;
  logic            sec_unused;

  // The secondary request never steers the grant: it is served by default.
  assign sec_unused = req_sec;

  req_history #(.DEPTH(TapW)) u_history (
    .clk    (clk),
    .rst    (rst),
    .req_in (req_pri),
    .taps   (pri_taps)
  );

  hold_window #(.DEPTH(TapW)) u_window (
    .taps (pri_taps),
    .busy (pri_busy)
  );

  grant_park u_park (
    .busy    (pri_busy),
    .gnt_pri (gnt_pri),
    .gnt_sec (gnt_sec)
  );

endmodule

// File: rtl/park_arbiter_checker.sv
module park_arbiter_checker #(
  parameter int HOLD_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic req_pri,
  input logic req_sec,
  input logic gnt_pri,
  input logic gnt_sec
);

  localparam int CntW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CntW-1:0] HoldVal = CntW'(HOLD_CYCLES);

  // Remaining cycles of the primary hold window, counted independently.
  logic [CntW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (req_pri)       left_q <= HoldVal;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assert_mutex_R1: assert property (@(posedge clk) disable iff (rst)
    !(gnt_pri && gnt_sec));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |-> gnt_pri);

  assert_first_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    req_pri |=> gnt_pri);

  assert_sec_alone_R3: assert property (@(posedge clk) disable iff (rst)
    (req_sec && !req_pri && left_q <= 1) |=> gnt_sec);

  assert_park_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!req_pri && !req_sec && left_q <= 1) |=> (gnt_sec && !gnt_pri));

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({gnt_pri, gnt_sec}) == 1);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    (left_q == '0) |-> !gnt_pri);

  assert_reset_exit_R7: assert property (@(posedge clk)
    rst |=> (!gnt_pri && gnt_sec));

endmodule

bind park_arbiter park_arbiter_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .req_pri (req_pri),
  .req_sec (req_sec),
  .gnt_pri (gnt_pri),
  .gnt_sec (gnt_sec)
);

// File: tb/park_arbiter_tb.sv
`timescale 1ns/1ps
module park_arbiter_tb;

  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_pri = 1'b0;
  logic req_sec = 1'b0;
  logic gnt_pri;
  logic gnt_sec;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  // Reference: primary requests sampled at the last HOLD rising edges.
  logic [HOLD-1:0] seen;

  always #2.5 clk = ~clk;

  park_arbiter #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .req_pri (req_pri),
    .req_sec (req_sec),
    .gnt_pri (gnt_pri),
    .gnt_sec (gnt_sec)
  );

  task automatic check(input string tag, input logic exp_pri, input logic exp_sec);
    n_checks++;
    if (gnt_pri !== exp_pri || gnt_sec !== exp_sec) begin
      n_fails++;
      $display("FAIL %s: got pri=%b sec=%b expected pri=%b sec=%b",
               tag, gnt_pri, gnt_sec, exp_pri, exp_sec);
    end
  endtask

  // Drive one cycle of requests, pass a rising edge, sample at the falling edge.
  task automatic step(input logic p, input logic s);
    req_pri = p;
    req_sec = s;
    @(posedge clk);
    if (rst) seen = '0;
    else     seen = {seen[HOLD-2:0], p};
    @(negedge clk);
  endtask

  task automatic step_check(input string tag, input logic p, input logic s);
    step(p, s);
    check(tag, |seen, ~(|seen));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    seen = '0;
    step(1'b1, 1'b1);
    check("R7 during reset", 1'b0, 1'b1);
    rst = 1'b0;
    step(1'b0, 1'b0);
    check("R7 after release", 1'b0, 1'b1);
    check("R5 after reset", 1'b0, 1'b1);
  endtask

  task automatic t_single_pulse();
    step_check("R2 pulse cycle 1", 1'b1, 1'b0);
    check("R2 hold first", 1'b1, 1'b0);
    step_check("R2 hold second", 1'b0, 1'b0);
    check("R2 hold second exp", 1'b1, 1'b0);
    step_check("R6 window closed", 1'b0, 1'b0);
    check("R6 no grant", 1'b0, 1'b1);
  endtask

  task automatic t_back_to_back();
    step_check("R9 b2b 1", 1'b1, 1'b0);
    step_check("R9 b2b 2", 1'b1, 1'b0);
    step_check("R9 b2b 3", 1'b1, 1'b0);
    step_check("R9 tail 1", 1'b0, 1'b0);
    check("R9 tail still primary", 1'b1, 1'b0);
    step_check("R9 tail end", 1'b0, 1'b0);
    check("R9 released", 1'b0, 1'b1);
    step_check("R9 gap pulse", 1'b1, 1'b0);
    step_check("R9 gap", 1'b0, 1'b0);
    step_check("R9 re-pulse", 1'b1, 1'b0);
    check("R9 no gap", 1'b1, 1'b0);
    step_check("R9 drain1", 1'b0, 1'b0);
    step_check("R9 drain2", 1'b0, 1'b0);
  endtask

  task automatic t_simultaneous();
    step_check("R8 both", 1'b1, 1'b1);
    check("R8 primary wins", 1'b1, 1'b0);
    step_check("R8 sec during hold", 1'b0, 1'b1);
    check("R8 sec ignored in hold", 1'b1, 1'b0);
    step_check("R3 sec after hold", 1'b0, 1'b1);
    check("R3 sec granted", 1'b0, 1'b1);
    step_check("R1 mutex", 1'b0, 1'b0);
    check("R1 one grant", 1'b0, 1'b1);
  endtask

  task automatic t_sec_only();
    step_check("R3 sec alone 1", 1'b0, 1'b1);
    check("R3 sec alone", 1'b0, 1'b1);
    step_check("R3 sec alone 2", 1'b0, 1'b1);
    step_check("R3 pri interrupts", 1'b1, 1'b1);
    check("R3 pri over sec", 1'b1, 1'b0);
    step_check("R3 tail", 1'b0, 1'b1);
    step_check("R3 back", 1'b0, 1'b1);
    check("R3 sec back", 1'b0, 1'b1);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 4; i++) begin
      step_check("R4 idle", 1'b0, 1'b0);
      check("R4 parked", 1'b0, 1'b1);
    end
  endtask

  task automatic t_reset_mid_hold();
    step_check("R7 pulse before reset", 1'b1, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b0);
    check("R7 reset clears hold", 1'b0, 1'b1);
    rst = 1'b0;
    step_check("R7 post", 1'b0, 1'b0);
  endtask

  initial begin
    seen = '0;
    @(negedge clk);
    t_reset();
    t_single_pulse();
    t_back_to_back();
    t_simultaneous();
    t_sec_only();
    t_idle();
    t_reset_mid_hold();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule